// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error-Tagged Receive Queue

This block recovers asynchronous serial characters from a single data line that is sampled on a sixteen-times-per-bit enable. It finds and confirms each start bit, shifts in the data bits and the optional parity bit, and checks the first stop bit. It then writes one 10-bit entry per character into a 16-deep receive queue. The parity-error and framing-error results travel inside each entry, so a reader always sees which character was damaged.

The consumer pops entries with a read strobe. Four status outputs describe the queue: data available, half full, full, and a sticky overrun flag for characters that arrived while the queue was full. An idle timer raises a flag when entries have been waiting for a programmable number of character times with no traffic. A receive-enable input gates reception. A loopback select feeds the local transmitter's output into the receiver in place of the external line. A flush strobe empties the queue.

Top module: `uart_rx_fifo`

## Requirements
- R1: Each entry is 10 bits. Bits [7:0] hold the data, with the first bit received in bit 0. Bit 8 is the parity-error flag and bit 9 is the framing-error flag. In the 7-bit format, data bit 7 of the entry is 0.
- R2: A low level seen on a tick starts a character only if the line is still low 8 ticks later, at the middle of the start bit. A shorter low pulse produces no entry. Each later bit is sampled 16 ticks after the previous one.
- R3: `fmt` selects the frame. 2'b00 and 2'b11 give 8 data bits with no parity, and the parity-error bit is then 0. 2'b01 gives 7 data bits plus parity. 2'b10 gives 8 data bits plus parity. In the parity formats, the parity-error bit is set when the parity does not match. With `odd_par`=0 the data and parity bits must hold an even number of ones; with `odd_par`=1 they must hold an odd number.
- R4: A low first stop bit sets the framing-error bit. After such a character, no new start is accepted until the line has been high on a tick, so a long break yields exactly one entry: 10'h200 in the 8-bit no-parity format.
- R5: Entries leave in arrival order. A `rd_en` pulse while the queue is non-empty removes the head entry and presents it on `rd_data` with `rd_valid` high in the next cycle. `rd_en` on an empty queue leaves `rd_valid` low.
- R6: `rx_avail` is high while the queue holds at least one entry. `half_full` is high while it holds 8 or more. `fifo_full` is high while it holds 16.
- R7: A character that completes while the queue is full and no read occurs is dropped, and `overrun` is set and stays set. Any accepted read clears `overrun`.
- R8: While the queue is non-empty, `idle_timeout` rises after `tmo_limit` character times (160 ticks each) with no received character, read or flush. A received character, a read or a flush clears it and restarts the count. A limit of 0 disables it.
- R9: While `rx_en` is low, no character is received and any partly received character is abandoned.
- R10: With `loop_en` high, the receiver takes its input from `tx_loop` and ignores `rx_line`.
- R11: A one-cycle `rx_flush` pulse empties the queue and clears `overrun` and `idle_timeout`.
- R12: After reset, the queue is empty and every status output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable, 16 per bit time |
| rx_line | input | 1 | External serial line, idle high |
| tx_loop | input | 1 | Local transmitter output used in loopback |
| loop_en | input | 1 | Selects `tx_loop` as the receiver input |
| rx_en | input | 1 | Receive enable |
| fmt | input | 2 | Frame format select |
| odd_par | input | 1 | Odd parity when high, even when low |
| tmo_limit | input | 8 | Idle timeout in character times, 0 disables |
| rx_flush | input | 1 | Empties the queue |
| rd_en | input | 1 | Pops the head entry |
| rd_data | output | 10 | Popped entry: {frame error, parity error, data} |
| rd_valid | output | 1 | `rd_data` holds a popped entry |
| rx_avail | output | 1 | Queue not empty |
| half_full | output | 1 | Queue holds 8 or more entries |
| fifo_full | output | 1 | Queue holds 16 entries |
| overrun | output | 1 | Sticky character-lost flag |
| idle_timeout | output | 1 | Idle timer expired |

## Verification
Random bytes are sent in every format and parity sense. Some frames carry deliberately flipped parity bits and low stop bits, which shows whether each flag lands on the right entry and bit, independently of the data. A run of 17 back-to-back characters exposes ordering errors, the half and full thresholds, and the point where a character is dropped. A long low level tells a break apart from an ordinary framing error. A short low pulse, a disabled receiver and a loopback with the external line held low each show whether the input is selected and qualified correctly. An idle hold with an observation window on each side of the expected expiry checks the timer's length.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int ENTRY_W = 10;

  localparam logic [1:0] FMT_8N = 2'b00;
  localparam logic [1:0] FMT_7P = 2'b01;
  localparam logic [1:0] FMT_8P = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic       frame_err;
    logic       par_err;
    logic [7:0] data;
  } rx_entry_t;
endpackage

// File: rtl/uart_rx_line_sel.sv
module uart_rx_line_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_line,
  input  logic tx_loop,
  input  logic loop_en,
  output logic line_o
);
  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q;

  assign raw = loop_en ? tx_loop : rx_line;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  assign line_o = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx_en,
  input  logic       line,
  input  logic [1:0] fmt,
  input  logic       odd_par,
  output logic       push_o,
  output rx_entry_t  entry_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e  st;
  logic [CW-1:0] cnt;
  logic [3:0] bitn;
  logic [3:0] nbits;
  logic [8:0] sh;
  logic [7:0] d_c;
  logic       pe_c;

  assign nbits = (fmt == FMT_8P) ? 4'd9 : 4'd8;

  always_comb begin
    case (fmt)
      FMT_8P: begin
        d_c  = sh[7:0];
        pe_c = (^sh[8:0]) ^ odd_par;
      end
      FMT_7P: begin
        d_c  = {1'b0, sh[7:1]};
        pe_c = (^sh[8:1]) ^ odd_par;
      end
      default: begin
        d_c  = sh[8:1];
        pe_c = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    push_o <= 1'b0;
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      sh      <= '0;
      entry_o <= '0;
    end else if (!rx_en) begin
      st <= ST_IDLE;
    end else if (tick) begin
      case (st)
        ST_IDLE: begin
          if (!line) begin
            st  <= ST_START;
            cnt <= '0;
          end
        end
        ST_START: begin
          if (cnt == MID) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= line ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_DATA: begin
          if (cnt == LAST) begin
            cnt  <= '0;
            sh   <= {line, sh[8:1]};
            bitn <= bitn + 4'd1;
            if (bitn == nbits - 4'd1) st <= ST_STOP;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_STOP: begin
          if (cnt == LAST) begin
            cnt               <= '0;
            push_o            <= 1'b1;
            entry_o.frame_err <= ~line;
            entry_o.par_err   <= pe_c;
            entry_o.data      <= d_c;
            st                <= line ? ST_IDLE : ST_HOLD;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_HOLD: begin
          if (line) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: a disabled receiver delivers nothing
  p_rxen_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !push_o);

  // R4: entries only come out of the stop-bit check
  p_push_from_stop_r4: assert property (@(posedge clk) disable iff (rst)
    push_o |-> $past(st) == ST_STOP);

  // R3: formats without parity never report a parity error
  p_nopar_clean_r3: assert property (@(posedge clk) disable iff (rst)
    push_o && ($past(fmt[1]) == $past(fmt[0])) |-> !entry_o.par_err);
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int W     = 10,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       dout_valid,
  output logic                       popped,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       ovr
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, is_full;

  assign is_full = (count == FULL_CNT);
  assign popped  = pop && (count != '0) && !flush;
  assign do_push = push && (!is_full || popped) && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (popped) dout <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp         <= '0;
      rp         <= '0;
      count      <= '0;
      ovr        <= 1'b0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= popped;
      if (do_push) wp <= wp + AW'(1);
      if (popped)  rp <= rp + AW'(1);
      if (do_push && !popped)      count <= count + (AW + 1)'(1);
      else if (popped && !do_push) count <= count - (AW + 1)'(1);
      if (popped)               ovr <= 1'b0;
      else if (push && !do_push) ovr <= 1'b1;
    end
  end

  // R7: a full queue keeps its contents when a character arrives
  p_full_hold_r7: assert property (@(posedge clk) disable iff (rst)
    push && is_full && !pop && !flush |=> count == FULL_CNT);

  // R7: the lost character raises the sticky flag
  p_ovr_set_r7: assert property (@(posedge clk) disable iff (rst)
    push && is_full && !pop && !flush |=> ovr);

  // R7: an accepted read clears the flag
  p_ovr_clr_r7: assert property (@(posedge clk) disable iff (rst)
    pop && (count != '0) |=> !ovr);

  // R5: reading an empty queue returns nothing
  p_pop_empty_r5: assert property (@(posedge clk) disable iff (rst)
    pop && (count == '0) |=> !dout_valid);
endmodule

// File: rtl/uart_rx_idle_timer.sv
module uart_rx_idle_timer #(
  parameter int OVS       = 16,
  parameter int CHAR_BITS = 10,
  parameter int TMO_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic             empty,
  input  logic [TMO_W-1:0] limit,
  output logic             tmo_o
);
  localparam int CHAR_TICKS = OVS * CHAR_BITS;
  localparam int TW = $clog2(CHAR_TICKS);
  localparam logic [TW-1:0] TLAST = TW'(CHAR_TICKS - 1);

  logic [TW-1:0]  tcnt;
  logic [TMO_W-1:0] ccnt;
  logic [TMO_W:0] cnext;

  assign cnext = {1'b0, ccnt} + (TMO_W + 1)'(1);

  always_ff @(posedge clk) begin
    if (rst || restart || empty) begin
      tcnt  <= '0;
      ccnt  <= '0;
      tmo_o <= 1'b0;
    end else if (tick) begin
      if (tcnt == TLAST) begin
        tcnt <= '0;
        if (ccnt != '1) ccnt <= cnext[TMO_W-1:0];
        if ((limit != '0) && (cnext >= {1'b0, limit})) tmo_o <= 1'b1;
      end else begin
        tcnt <= tcnt + TW'(1);
      end
    end
  end

  // R8: traffic or a flush drops the flag
  p_tmo_restart_r8: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tmo_o);

  // R8: an empty queue never times out
  p_tmo_empty_r8: assert property (@(posedge clk) disable iff (rst)
    empty |-> !tmo_o);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int OVS         = 16,
  parameter int CHAR_BITS   = 10,
  parameter int TMO_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick16,
  input  logic               rx_line,
  input  logic               tx_loop,
  input  logic               loop_en,
  input  logic               rx_en,
  input  logic [1:0]         fmt,
  input  logic               odd_par,
  input  logic [TMO_W-1:0]   tmo_limit,
  input  logic               rx_flush,
  input  logic               rd_en,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               rd_valid,
  output logic               rx_avail,
  output logic               half_full,
  output logic               fifo_full,
  output logic               overrun,
  output logic               idle_timeout
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);
  localparam logic [AW:0] HALF_CNT = (AW + 1)'(DEPTH / 2);

  logic          line_s;
  logic          push;
  rx_entry_t     entry;
  logic          popped;
  logic [AW:0]   count;

  uart_rx_line_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .rx_line (rx_line),
    .tx_loop (tx_loop),
    .loop_en (loop_en),
    .line_o  (line_s)
  );

  uart_rx_deframer #(.OVS(OVS)) u_deframe (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick16),
    .rx_en   (rx_en),
    .line    (line_s),
    .fmt     (fmt),
    .odd_par (odd_par),
    .push_o  (push),
    .entry_o (entry)
  );

  uart_rx_queue #(.W(ENTRY_W), .DEPTH(DEPTH)) u_queue (
    .clk        (clk),
    .rst        (rst),
    .flush      (rx_flush),
    .push       (push),
    .din        (entry),
    .pop        (rd_en),
    .dout       (rd_data),
    .dout_valid (rd_valid),
    .popped     (popped),
    .count      (count),
    .ovr        (overrun)
  );

  uart_rx_idle_timer #(.OVS(OVS), .CHAR_BITS(CHAR_BITS), .TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick16),
    .restart (push | popped | rx_flush),
    .empty   (count == '0),
    .limit   (tmo_limit),
    .tmo_o   (idle_timeout)
  );

  assign rx_avail  = (count != '0);
  assign half_full = (count >= HALF_CNT);
  assign fifo_full = (count == FULL_CNT);
endmodule

// File: tb/uart_rx_fifo_tb.sv
module uart_rx_fifo_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rx_drv = 1'b1, tx_drv = 1'b1;
  logic       loop_en = 1'b0, rx_en = 1'b1;
  logic [1:0] fmt = 2'b00;
  logic       odd = 1'b0;
  logic [7:0] tmo_limit = 8'd20;
  logic       rx_flush = 1'b0, rd_en = 1'b0;
  logic [9:0] rd_data;
  logic       rd_valid, rx_avail, half_full, fifo_full, overrun, idle_timeout;

  int nchk = 0, nerr = 0;
  logic [9:0] q[$];

  always #4 clk = ~clk;

  uart_rx_fifo u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_line(rx_drv), .tx_loop(tx_drv),
    .loop_en(loop_en), .rx_en(rx_en), .fmt(fmt), .odd_par(odd),
    .tmo_limit(tmo_limit), .rx_flush(rx_flush), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .rx_avail(rx_avail),
    .half_full(half_full), .fifo_full(fifo_full), .overrun(overrun),
    .idle_timeout(idle_timeout)
  );

  initial begin
    int tdiv = 0;
    forever begin
      @(negedge clk);
      tdiv++;
      tick16 = (tdiv % 4 == 0);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_entry(input logic [1:0] f, input logic [7:0] d,
                                           input logic flip, input logic stopbad);
    logic [7:0] dd = (f == 2'b01) ? {1'b0, d[6:0]} : d;
    logic pe = (f == 2'b01 || f == 2'b10) ? flip : 1'b0;
    return {stopbad, pe, dd};
  endfunction

  task automatic drive_bit(input logic v, input bit lp);
    if (lp) tx_drv = v; else rx_drv = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic flip, input logic stopbad, input bit lp);
    int nd = (fmt == 2'b01) ? 7 : 8;
    logic p = ((fmt == 2'b01) ? ^d[6:0] : ^d) ^ odd ^ flip;
    drive_bit(1'b0, lp);
    for (int i = 0; i < nd; i++) drive_bit(d[i], lp);
    if (fmt == 2'b01 || fmt == 2'b10) drive_bit(p, lp);
    drive_bit(!stopbad, lp);
    drive_bit(1'b1, lp);
  endtask

  task automatic pop_chk(input string tag, input logic [9:0] exp);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    chk({tag, " valid"}, rd_valid, 1);
    chk(tag, rd_data, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic flip, sb;
    void'($urandom(32'h5A17));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 avail", rx_avail, 0);
    chk("R12 half", half_full, 0);
    chk("R12 full", fifo_full, 0);
    chk("R12 overrun", overrun, 0);
    chk("R12 timeout", idle_timeout, 0);
    chk("R12 valid", rd_valid, 0);

    // R1 R3 R4 R5: random characters in random formats
    for (int r = 0; r < 4; r++) begin
      fmt = 2'($urandom % 4);
      odd = 1'($urandom % 2);
      for (int k = 0; k < 2 + int'($urandom % 7); k++) begin
        d = 8'($urandom);
        flip = (fmt == 2'b01 || fmt == 2'b10) && ($urandom % 3 == 0);
        sb = ($urandom % 6 == 0);
        q.push_back(exp_entry(fmt, d, flip, sb));
        send(d, flip, sb, 1'b0);
      end
      while (q.size() > 0) pop_chk("R1 R3 R4 random entry", q.pop_front());
      chk("R5 drained", rx_avail, 0);
    end

    // R3 directed: odd parity, correct and wrong, 7-bit format
    fmt = 2'b01; odd = 1'b1;
    send(8'hD5, 1'b0, 1'b0, 1'b0);
    send(8'h3C, 1'b1, 1'b0, 1'b0);
    pop_chk("R3 odd parity good", 10'h055);
    pop_chk("R3 odd parity bad", 10'h13C);

    // R5 read of an empty queue
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    chk("R5 empty read", rd_valid, 0);

    // R2 short low pulse is not a start bit
    fmt = 2'b00; odd = 1'b0;
    rx_drv = 1'b0;
    repeat (12) @(negedge clk);
    rx_drv = 1'b1;
    repeat (1000) @(negedge clk);
    chk("R2 glitch rejected", rx_avail, 0);

    // R4 long break gives one entry
    drive_bit(1'b0, 1'b0);
    repeat (19) drive_bit(1'b0, 1'b0);
    repeat (3) drive_bit(1'b1, 1'b0);
    pop_chk("R4 break entry", 10'h200);
    chk("R4 single break entry", rx_avail, 0);

    // R9 receiver disabled
    rx_en = 1'b0;
    send(8'hA6, 1'b0, 1'b0, 1'b0);
    rx_en = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 disabled", rx_avail, 0);

    // R10 loopback, external line held low
    loop_en = 1'b1;
    rx_drv = 1'b0;
    repeat (8) @(negedge clk);
    send(8'h4B, 1'b0, 1'b0, 1'b1);
    pop_chk("R10 loopback entry", 10'h04B);
    chk("R10 external ignored", rx_avail, 0);
    rx_drv = 1'b1;
    repeat (8) @(negedge clk);
    loop_en = 1'b0;
    repeat (8) @(negedge clk);

    // R6 R7 fill beyond depth
    for (int i = 0; i < 16; i++) begin
      send(8'(i * 13 + 1), 1'b0, 1'b0, 1'b0);
      if (i == 6) chk("R6 half at 7", half_full, 0);
      if (i == 7) chk("R6 half at 8", half_full, 1);
    end
    chk("R6 full", fifo_full, 1);
    chk("R7 no overrun yet", overrun, 0);
    send(8'hEE, 1'b0, 1'b0, 1'b0);
    chk("R7 overrun set", overrun, 1);
    pop_chk("R5 R7 head kept", {2'b00, 8'(1)});
    chk("R7 overrun cleared", overrun, 0);
    chk("R6 not full", fifo_full, 0);
    send(8'h77, 1'b0, 1'b0, 1'b0);
    send(8'h88, 1'b0, 1'b0, 1'b0);
    chk("R7 overrun again", overrun, 1);

    // R11 flush
    @(negedge clk) rx_flush = 1'b1;
    @(negedge clk) rx_flush = 1'b0;
    chk("R11 empty", rx_avail, 0);
    chk("R11 overrun cleared", overrun, 0);
    chk("R11 full cleared", fifo_full, 0);
    send(8'h19, 1'b0, 1'b0, 1'b0);
    pop_chk("R11 new entry after flush", 10'h019);

    // R8 idle timeout
    tmo_limit = 8'd3;
    send(8'h62, 1'b0, 1'b0, 1'b0);
    repeat (1785) @(negedge clk);
    chk("R8 before expiry", idle_timeout, 0);
    repeat (80) @(negedge clk);
    chk("R8 after expiry", idle_timeout, 1);
    pop_chk("R8 entry", 10'h062);
    chk("R8 cleared by read", idle_timeout, 0);

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule